// File: doc/BRIEF.md
# Timer-Compare Output Event Scheduler

This block keeps a small associative table of pending output events. Software first writes a 7-bit command word and then a 16-bit trigger time. The time write captures both values together into a holding register. On the following clock edge the held pair drops into the lowest-numbered free slot of an 8-slot table.

Every cycle, each occupied slot compares its stored time against one of two free-running timers, and the command picks which one. On a match the slot fires on the next clock edge and is freed on that same edge. Channels 0 to 5 set or clear one of six output lines. Channels 8 to 15 pulse an internal event strobe for one cycle. A fired command can also pulse the interrupt line. If the table is full, the held pair waits and a full indication is raised.

Top module: `evt_sched`

## Requirements
- R1: After reset, pins_o, evt_o and irq_o are all zero, full_o is low, and the table and holding register are empty.
- R2: A command write stores wdata_i[6:0] as the command word. A time write captures the stored command together with wdata_i[15:0] into the holding register, which is valid from the next cycle. Later command writes do not change a held pair.
- R3: A valid held pair moves into the lowest-numbered free slot on the next clock edge. The slot takes part in comparison from the cycle after that edge.
- R4: full_o is high while a held pair is valid and all 8 slots are occupied. The pair then stays held until a slot frees.
- R5: Command bit 6 selects the time base: 0 compares against timer0_i and 1 against timer1_i. A slot whose time equals its timer in a cycle fires on the next rising edge.
- R6: Command bits 3:0 hold the channel. For channels 0 to 5, a firing command sets pins_o[channel] when bit 5 is 1 and clears it when bit 5 is 0. The pins hold their value otherwise.
- R7: A firing command on channel 8 to 15 drives evt_o[channel-8] high for exactly one cycle, whatever bit 5 holds. Channels 6 and 7 change neither pins_o nor evt_o.
- R8: A firing command with bit 4 set drives irq_o high for one cycle after the firing edge. Without bit 4, it does not.
- R9: A slot is freed on the edge on which it fires, so each loaded pair fires at most once.
- R10: All slots that match in the same cycle fire together. When a set and a clear of the same pin fire together, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command word write strobe |
| time_we_i | input | 1 | Trigger time write strobe; loads the holding register |
| wdata_i | input | 16 | Write data for both strobes |
| timer0_i | input | 16 | Time base selected by command bit 6 = 0 |
| timer1_i | input | 16 | Time base selected by command bit 6 = 1 |
| pins_o | output | 6 | Output lines driven by channels 0 to 5 |
| evt_o | output | 8 | One-cycle strobes for channels 8 to 15 |
| irq_o | output | 1 | One-cycle interrupt pulse |
| full_o | output | 1 | Held pair waiting because the table is full |

## Verification
The bench uses the default parameters: 8 slots, 16-bit times, 6 pins and 16 channels. With only eight slots, a burst of directed writes fills the table and reaches the full condition and the hold-back behaviour. The bench drives timer0_i every cycle and timer1_i every fourth cycle. Random trigger times a few tens of ticks ahead therefore produce frequent same-cycle matches, mixed set and clear on one pin, and reuse of freed slots.

// File: rtl/evt_sched_pkg.sv
package evt_sched_pkg;
  localparam int CMD_W = 7;
  localparam int CH_W  = 4;

  // bit6 time base, bit5 set/clear, bit4 irq enable, bits3:0 channel
  typedef struct packed {
    logic            tsel;
    logic            set;
    logic            irq_en;
    logic [CH_W-1:0] ch;
  } cmd_t;
endpackage

// File: rtl/evt_sched_hold.sv
module evt_sched_hold
  import evt_sched_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic          time_we_i,
  input  logic [TW-1:0] wdata_i,
  input  logic          take_i,
  output logic          hold_v_o,
  output cmd_t          hold_cmd_o,
  output logic [TW-1:0] hold_time_o
);
  cmd_t cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= '0;
    else if (cmd_we_i) cmd_q <= cmd_t'(wdata_i[CMD_W-1:0]);
  end

  // time write captures command and time together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_o    <= 1'b0;
      hold_cmd_o  <= '0;
      hold_time_o <= '0;
    end else if (time_we_i) begin
      hold_v_o    <= 1'b1;
      hold_cmd_o  <= cmd_q;
      hold_time_o <= wdata_i;
    end else if (take_i) begin
      hold_v_o    <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_sched_cam.sv
module evt_sched_cam
  import evt_sched_pkg::*;
#(
  parameter int N_ENT = 8,
  parameter int TW    = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   hold_v_i,
  input  cmd_t                   hold_cmd_i,
  input  logic [TW-1:0]          hold_time_i,
  input  logic [TW-1:0]          timer0_i,
  input  logic [TW-1:0]          timer1_i,
  output logic                   take_o,
  output logic                   full_o,
  output logic [N_ENT-1:0]       ent_v_o,
  output logic [N_ENT-1:0]       fire_o,
  output cmd_t [N_ENT-1:0]       ent_cmd_o
);
  logic [N_ENT-1:0] sel;
  logic             found;

  // lowest-numbered free slot
  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      if (!ent_v_o[i] && !found) begin
        sel[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  assign take_o = hold_v_i && found;
  assign full_o = hold_v_i && !found;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic [TW-1:0] time_q;
    logic [TW-1:0] base;

    assign base       = ent_cmd_o[g].tsel ? timer1_i : timer0_i;
    assign fire_o[g]  = ent_v_o[g] && (time_q == base);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_v_o[g]   <= 1'b0;
        ent_cmd_o[g] <= '0;
        time_q       <= '0;
      end else if (take_o && sel[g]) begin
        ent_v_o[g]   <= 1'b1;
        ent_cmd_o[g] <= hold_cmd_i;
        time_q       <= hold_time_i;
      end else if (fire_o[g]) begin
        ent_v_o[g]   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/evt_sched_out.sv
module evt_sched_out
  import evt_sched_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter int N_PINS = 6,
  parameter int N_CH   = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_ENT-1:0]           fire_i,
  input  logic [N_ENT-1:0][CH_W-1:0] ch_i,
  input  logic [N_ENT-1:0]           set_i,
  input  logic [N_ENT-1:0]           irq_en_i,
  output logic [N_PINS-1:0]          pins_o,
  output logic [N_CH/2-1:0]          evt_o,
  output logic                       irq_o
);
  localparam int EVT_BASE = N_CH / 2;
  localparam int N_EVT    = N_CH - EVT_BASE;

  logic [N_PINS-1:0] set_m, clr_m;
  logic [N_EVT-1:0]  evt_d;
  logic              irq_d;

  always_comb begin
    set_m = '0;
    clr_m = '0;
    evt_d = '0;
    irq_d = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      if (fire_i[i]) begin
        if (irq_en_i[i]) irq_d = 1'b1;
        for (int p = 0; p < N_PINS; p++) begin
          if (ch_i[i] == CH_W'(p)) begin
            if (set_i[i]) set_m[p] = 1'b1;
            else          clr_m[p] = 1'b1;
          end
        end
        for (int k = 0; k < N_EVT; k++) begin
          if (ch_i[i] == CH_W'(EVT_BASE + k)) evt_d[k] = 1'b1;
        end
      end
    end
  end

  // clear beats set on the same pin
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pins_o <= '0;
      evt_o  <= '0;
      irq_o  <= 1'b0;
    end else begin
      pins_o <= (pins_o | set_m) & ~clr_m;
      evt_o  <= evt_d;
      irq_o  <= irq_d;
    end
  end
endmodule

// File: rtl/evt_sched.sv
module evt_sched
  import evt_sched_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter int TW     = 16,
  parameter int N_PINS = 6,
  parameter int N_CH   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic              time_we_i,
  input  logic [TW-1:0]     wdata_i,
  input  logic [TW-1:0]     timer0_i,
  input  logic [TW-1:0]     timer1_i,
  output logic [N_PINS-1:0] pins_o,
  output logic [N_CH/2-1:0] evt_o,
  output logic              irq_o,
  output logic              full_o
);
  logic                       hold_v, take;
  cmd_t                       hold_cmd;
  logic [TW-1:0]              hold_time;
  logic [N_ENT-1:0]           ent_v, fire;
  cmd_t [N_ENT-1:0]           ent_cmd;
  logic [N_ENT-1:0][CH_W-1:0] ent_ch;
  logic [N_ENT-1:0]           ent_set, ent_irq;

  evt_sched_hold #(.TW(TW)) i_hold (
    .clk_i, .rst_ni, .cmd_we_i, .time_we_i, .wdata_i,
    .take_i(take), .hold_v_o(hold_v), .hold_cmd_o(hold_cmd), .hold_time_o(hold_time)
  );

  evt_sched_cam #(.N_ENT(N_ENT), .TW(TW)) i_cam (
    .clk_i, .rst_ni, .hold_v_i(hold_v), .hold_cmd_i(hold_cmd), .hold_time_i(hold_time),
    .timer0_i, .timer1_i, .take_o(take), .full_o,
    .ent_v_o(ent_v), .fire_o(fire), .ent_cmd_o(ent_cmd)
  );

  for (genvar g = 0; g < N_ENT; g++) begin : g_fld
    assign ent_ch[g]  = ent_cmd[g].ch;
    assign ent_set[g] = ent_cmd[g].set;
    assign ent_irq[g] = ent_cmd[g].irq_en;
  end

  evt_sched_out #(.N_ENT(N_ENT), .N_PINS(N_PINS), .N_CH(N_CH)) i_out (
    .clk_i, .rst_ni, .fire_i(fire), .ch_i(ent_ch), .set_i(ent_set), .irq_en_i(ent_irq),
    .pins_o, .evt_o, .irq_o
  );
endmodule

// File: rtl/evt_sched_chk.sv
module evt_sched_chk #(
  parameter int N_ENT  = 8,
  parameter int N_PINS = 6,
  parameter int N_EVT  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              time_we_i,
  input logic              full_o,
  input logic              irq_o,
  input logic [N_EVT-1:0]  evt_o,
  input logic [N_PINS-1:0] pins_o,
  input logic              hold_v_i,
  input logic [N_ENT-1:0]  ent_v_i,
  input logic [N_ENT-1:0]  fire_i
);
  // R2
  hold_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_we_i |=> hold_v_i);

  // R3
  hold_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_v_i && !full_o && !time_we_i) |=> !hold_v_i);

  // R4
  hold_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> hold_v_i);

  // R6
  pin_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pins_o) |-> $past(|fire_i));

  // R7
  evt_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o != '0) |-> $past(|fire_i));

  // R8
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(|fire_i));

  // R9
  fire_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fire_i) |=> ((ent_v_i & $past(fire_i)) == '0));
endmodule

bind evt_sched evt_sched_chk #(.N_ENT(N_ENT), .N_PINS(N_PINS), .N_EVT(N_CH/2)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .time_we_i(time_we_i), .full_o(full_o),
  .irq_o(irq_o), .evt_o(evt_o), .pins_o(pins_o), .hold_v_i(hold_v),
  .ent_v_i(ent_v), .fire_i(fire)
);

// File: tb/test_evt_sched.sv
module test_evt_sched;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_we_i = 1'b0, time_we_i = 1'b0;
  logic [15:0] wdata_i = '0, timer0_i = '0, timer1_i = '0;
  logic [5:0]  pins_o;
  logic [7:0]  evt_o;
  logic        irq_o, full_o;

  int checks = 0, fails = 0;
  bit done = 0;
  int unsigned cyc = 0;

  // reference state
  bit        mv [8];
  bit [6:0]  mc [8];
  bit [15:0] mt [8];
  bit        mhv;
  bit [6:0]  mhc, mcmd;
  bit [15:0] mht;
  bit [5:0]  m_pins;
  bit [7:0]  m_evt;
  bit        m_irq;

  always #5 clk_i = ~clk_i;

  evt_sched i_evt_sched (.*);

  function automatic bit m_full();
    bit all = 1;
    for (int i = 0; i < 8; i++) if (!mv[i]) all = 0;
    return mhv && all;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic void m_step(bit cw, bit tw, bit [15:0] wd, bit [15:0] t0, bit [15:0] t1);
    bit [7:0] f = '0;
    bit [5:0] s = '0, c = '0;
    bit [7:0] e = '0;
    bit irq = 0, took = 0;
    bit ov [8];
    int k = 0, ch;
    for (int i = 0; i < 8; i++) begin
      ov[i] = mv[i];
      f[i] = mv[i] && (mt[i] == (mc[i][6] ? t1 : t0));
    end
    for (int i = 0; i < 8; i++) if (f[i]) begin
      ch = mc[i][3:0];
      if (mc[i][4]) irq = 1;
      if (ch < 6) begin if (mc[i][5]) s[ch] = 1; else c[ch] = 1; end
      if (ch >= 8) e[ch-8] = 1;
    end
    m_pins = (m_pins | s) & ~c;
    m_evt = e;
    m_irq = irq;
    for (int i = 0; i < 8; i++) if (f[i]) mv[i] = 0;
    if (mhv) begin
      for (int i = 7; i >= 0; i--) if (!ov[i]) begin k = i; took = 1; end
      if (took) begin mv[k] = 1; mc[k] = mhc; mt[k] = mht; end
    end
    if (tw) begin mhv = 1; mhc = mcmd; mht = wd; end
    else if (took) mhv = 0;
    if (cw) mcmd = wd[6:0];
  endfunction

  function automatic bit [15:0] t0_now(); return 16'(cyc); endfunction
  function automatic bit [15:0] t1_now(); return 16'(cyc / 4); endfunction

  // one clock: drive at negedge, step reference, compare at next negedge
  task automatic cycle(bit cw, bit tw, bit [15:0] wd);
    cmd_we_i = cw; time_we_i = tw; wdata_i = wd;
    timer0_i = t0_now(); timer1_i = t1_now();
    m_step(cw, tw, wd, timer0_i, timer1_i);
    @(posedge clk_i);
    @(negedge clk_i);
    cyc++;
    chk("R5 R6 R9 R10 pins", pins_o, m_pins);
    chk("R5 R7 R9 evt", evt_o, m_evt);
    chk("R8 R9 irq", irq_o, m_irq);
    chk("R2 R3 R4 full", full_o, m_full());
  endtask

  task automatic put(bit [6:0] cmd, bit [15:0] tm);
    cycle(1, 0, {9'd0, cmd});
    cycle(0, 1, tm);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(0, 0, '0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) begin mv[i] = 0; mc[i] = 0; mt[i] = 0; end
    mhv = 0; mhc = 0; mcmd = 0; mht = 0; m_pins = 0; m_evt = 0; m_irq = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 pins", pins_o, 0);
    chk("R1 evt", evt_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 full", full_o, 0);

    // R6 R8: set pin 2 with irq, later clear it
    put(7'h32, t0_now() + 16'd6);
    idle(8);
    chk("R6 pin2 set", pins_o[2], 1);
    put(7'h02, t0_now() + 16'd5);
    idle(8);
    chk("R6 pin2 cleared", pins_o[2], 0);

    // R10: set and clear of pin 1 at one time, clear wins
    put(7'h21, t0_now() + 16'd20);
    put(7'h31, t0_now() + 16'd18);
    put(7'h01, t0_now() + 16'd16);
    idle(22);
    chk("R10 pin1 clear wins", pins_o[1], 0);

    // R7: channels 6,7 silent; channel 12 strobes regardless of bit 5
    put(7'h26, t0_now() + 16'd8);
    put(7'h17, t0_now() + 16'd6);
    put(7'h0c, t0_now() + 16'd10);
    put(7'h2c, t0_now() + 16'd14);
    idle(16);

    // R5: timer1 base
    put(7'h63, t1_now() + 16'd3);
    idle(20);
    chk("R5 timer1 pin3", pins_o[3], 1);

    // R3 R4: fill all slots, one more waits
    for (int i = 0; i < 9; i++) put(7'(8 + i % 8), t0_now() + 16'd60 + 16'(i));
    chk("R4 full raised", full_o, 1);
    idle(80);
    chk("R4 full gone", full_o, 0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom % 10);
      if (r == 0) cycle(1, 0, 16'($urandom % 128));
      else if (r == 1) begin
        if (mcmd[6]) cycle(0, 1, t1_now() + 16'(2 + $urandom % 12));
        else         cycle(0, 1, t0_now() + 16'(2 + $urandom % 50));
      end else idle(1);
    end
    idle(100);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule